// File: doc/BRIEF.md
# Debounced Pushbutton Step Counter

This block counts presses of a mechanical pushbutton. The button line is active-low: a pull-up holds it high, and pressing the button pulls it low. The contacts bounce, so the raw line is first brought into the clock domain by a chain of flip-flops. It is then looked at only when a free-running prescaler rolls over. If all of the bounce for one edge fits inside a single sample interval, the sampled level changes once per press and once per release.

A falling edge of the sampled level produces an enable pulse one clock wide. That pulse advances a small binary counter by one, and the counter wraps from its top value back to zero. The count bits and a terminal-count flag leave the block inverted, so they can drive lamps that light when their pin is low. There is no data stream, so every pin is a plain control or status pin.

Top module: `stepctr_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 0 and the debounced level becomes released (high). After reset, `cnt_lamp_n` reads all ones and `tc_lamp_n` reads 1. Reset by itself never counts as a press.
- R2: A press adds exactly 1 to the count. A press is a transition from high to low on `btn_n` that then stays low for at least two sample periods.
- R3: Bounce adds no extra counts, provided the toggling around a press or a release lasts less than one sample period of 2^PRESCALE_W clocks.
- R4: Holding the button low for any length of time after the first increment adds nothing further.
- R5: A press at count 2^CNT_W-1 (111 for the default width) brings the count to 0.
- R6: `tc_lamp_n` is 0 exactly when every count bit is 1, and is 1 otherwise.
- R7: `cnt_lamp_n[i]` is the inverse of count bit i, with bit 0 as the least significant bit.
- R8: The sample strobe is high for one clock in every 2^PRESCALE_W, on the cycle the prescaler holds all ones. The debounced level changes only on the edge that follows a strobe.
- R9: The increment enable lasts exactly one clock per falling edge of the debounced level. The count changes only on the edge that follows that enable, or on reset.
- R10: Reset clears the count on the next edge, whatever level the button is at.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_n | input | 1 | Raw pushbutton line, low while pressed, asynchronous |
| cnt_lamp_n | output | CNT_W | Count, inverted, for active-low lamps |
| tc_lamp_n | output | 1 | Terminal count, low when the count is all ones |

## Verification
The bench builds the block with PRESCALE_W = 3, which gives an 8-clock sample period, and keeps the default 3-bit count and the two synchronizer stages. With so short a sample period, a press costs only a few dozen clocks. Many presses therefore fit in one run, including several passes through the 111-to-000 wrap and the terminal-count lamp. Random bounce bursts of up to six clocks are placed next to strobes at every possible phase, so the one-sample-per-window debounce rule is exercised from all sides.

// File: rtl/stepctr_pkg.sv
package stepctr_pkg;
  localparam int unsigned DEF_CNT_W   = 3;
  localparam int unsigned DEF_PRE_W   = 16;
  localparam int unsigned DEF_STAGES  = 2;
  // released level of the active-low button line
  localparam logic BTN_IDLE = 1'b1;
endpackage

// File: rtl/stepctr_sync.sv
module stepctr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  import stepctr_pkg::*;
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= BTN_IDLE;
        else     chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{BTN_IDLE}};
        else     chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/stepctr_sampler.sv
module stepctr_sampler #(
  parameter int unsigned PRE_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  output logic step
);
  import stepctr_pkg::*;
  logic [PRE_W-1:0] pre;
  logic             strobe;
  logic             db_lvl;
  logic             db_prev;

  always_ff @(posedge clk) begin
    if (rst) pre <= '0;
    else     pre <= pre + 1'b1;
  end

  assign strobe = &pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      db_lvl  <= BTN_IDLE;
      db_prev <= BTN_IDLE;
    end else begin
      if (strobe) db_lvl <= lvl_in;
      db_prev <= db_lvl;
    end
  end

  assign step = db_prev & ~db_lvl;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe); // R8
  AST_DB_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(db_lvl)); // R8
  AST_STEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    step |=> !step); // R9
endmodule

// File: rtl/stepctr_count.sv
module stepctr_count #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_top
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + CNT_W'(1);
  end

  assign at_top = &cnt;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cnt == '0)); // R10
  AST_INC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    inc |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R2
  AST_HOLD_NO_INC: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt)); // R9
endmodule

// File: rtl/stepctr_top.sv
module stepctr_top #(
  parameter int unsigned CNT_W      = stepctr_pkg::DEF_CNT_W,
  parameter int unsigned PRESCALE_W = stepctr_pkg::DEF_PRE_W,
  parameter int unsigned SYNC_STAGES = stepctr_pkg::DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_n,
  output logic [CNT_W-1:0] cnt_lamp_n,
  output logic             tc_lamp_n
);
  logic             btn_s;
  logic             step;
  logic [CNT_W-1:0] cnt;
  logic             at_top;

  stepctr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(btn_n), .d_sync(btn_s));

  stepctr_sampler #(.PRE_W(PRESCALE_W)) u_samp (
    .clk(clk), .rst(rst), .lvl_in(btn_s), .step(step));

  stepctr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(step), .cnt(cnt), .at_top(at_top));

  assign cnt_lamp_n = ~cnt;
  assign tc_lamp_n  = ~at_top;

  AST_RESET_LAMPS_OFF: assert property (@(posedge clk)
    rst |=> (cnt_lamp_n == '1 && tc_lamp_n)); // R1
  AST_TC_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    !tc_lamp_n |-> (cnt_lamp_n == '0)); // R6
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step && !tc_lamp_n) |=> (cnt_lamp_n == '1)); // R5
endmodule

// File: tb/stepctr_top_test.sv
module stepctr_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 3;
  localparam int PW  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          btn_n = 1'b1;
  logic [CW-1:0] cnt_lamp_n;
  logic          tc_lamp_n;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  stepctr_top #(.CNT_W(CW), .PRESCALE_W(PW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .btn_n(btn_n),
    .cnt_lamp_n(cnt_lamp_n), .tc_lamp_n(tc_lamp_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [CW:0] lamps_for(int c);
    logic [CW-1:0] v;
    v = CW'(c);
    return {~(&v), ~v};
  endfunction

  task automatic check(string req);
    logic [CW:0] got, exp;
    got = {tc_lamp_n, cnt_lamp_n};
    exp = lamps_for(exp_cnt);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // bursts of random toggling no longer than 6 clocks, then settle
  task automatic bounce_to(logic lvl);
    int w = $urandom_range(1, 6);
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      btn_n = 1'($urandom % 2);
    end
    @(negedge clk);
    btn_n = lvl;
  endtask

  task automatic press(int hold, int rel, string req);
    bounce_to(1'b0);
    idle(hold);
    bounce_to(1'b1);
    idle(rel);
    exp_cnt = (exp_cnt + 1) % (1 << CW);
    check(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle(4);
    check("R1 reset state");
    rst = 1'b0;
    idle(30);
    check("R1 no press after reset");

    // directed: count up through the top value and the wrap
    for (int k = 0; k < 9; k++) begin
      press(24, 24, "R2 R3 R7 step");
      if (exp_cnt == 7) check("R6 terminal count at 111");
      if (exp_cnt == 0) check("R5 wrap to 000");
    end

    // long hold: a single increment only
    bounce_to(1'b0);
    idle(30);
    exp_cnt = (exp_cnt + 1) % (1 << CW);
    check("R4 first increment while held");
    idle(200);
    check("R4 no further increments while held");
    bounce_to(1'b1);
    idle(30);
    check("R4 release adds nothing");

    // reset while the button is held down
    bounce_to(1'b0);
    idle(30);
    @(negedge clk); rst = 1'b1;
    idle(2);
    exp_cnt = 0;
    check("R10 reset clears count with button low");
    btn_n = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(30);
    check("R1 R10 count stays zero after reset");

    // random presses
    for (int k = 0; k < 40; k++) begin
      press($urandom_range(18, 60), $urandom_range(20, 60), "R2 R3 random press");
      if (exp_cnt == 7) check("R6 terminal count random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule